// File: doc/BRIEF.md
# DMA Bus Tenure Limiting Timer

This block limits how long a bus-mastering DMA engine keeps the system bus in one tenure. Software writes a 16-bit limit in steps of 0.1 microsecond; a value of 510 means 51 microseconds. The write goes through a 32-bit register port, and that port accepts accesses only while the engine's stop flag is raised. When the engine gains the bus, a countdown loads the limit. A prescaler turns clock cycles into 0.1 microsecond ticks. When the countdown reaches zero, the block flags expiry.

Expiry does not take the bus away at once. The release request waits for a legal stopping point. In linear-burst mode that point is the last transfer of the current burst. Otherwise it is the completion of a group of three data transfers, with groups counted from the start of the tenure. Descriptor transfers never produce the stopping point. Because of this, a zero limit still lets each tenure carry exactly one burst or one group of three. A test mode stops the prescaler, so the counter then moves down by one on each accepted register write.

No data stream passes through the block, so it has no valid/ready pair and applies no back-pressure. Every pin is a plain level or single-cycle strobe, sampled on the rising clock edge.

Top module: `bus_tenure_limiter`

## Requirements
- R1: A write (reg_wr) stores reg_wdata[15:0] as the limit only while stop is high; writes with stop low are ignored. A read (reg_rd with stop high) returns {16'h0000, limit} on reg_rdata in the same cycle. In every other cycle reg_rdata is zero. Bits 31:16 of the write data are discarded.
- R2: An asynchronous hardware reset (rst_n low) and a synchronous software reset (sw_reset high) both clear the limit to zero. Raising or lowering stop leaves the limit unchanged.
- R3: On the first clock edge that samples grant high, the countdown loads the limit and the prescaler restarts. With the limit L and TICK_DIV clocks per tick, expired goes high exactly L*TICK_DIV edges after that load edge. With L = 0 it goes high at the load edge itself.
- R4: expired stays high for as long as grant stays high. It is low after the first edge that samples grant low.
- R5: With timer_en low, release_req is never asserted.
- R6: With burst_mode high, release_req rises on the edge that samples a data transfer (xfer_done high, desc_phase low) with burst_last high while expired is high. Transfers with burst_last low do not raise it.
- R7: With burst_mode low, data transfers are counted in groups of three from the start of the tenure. release_req rises on the edge of a group's third transfer if expired is high at that edge.
- R8: With a zero limit and timer_en high, release_req rises at the first burst end in burst mode, or at the third data transfer otherwise.
- R9: A transfer with desc_phase high does not advance the group count and never raises release_req.
- R10: With test_en high, the prescaler does not tick. Each accepted register write moves the countdown down by one, saturating at zero.
- R11: Once raised, release_req stays high until an edge samples grant low, and it is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_reset | input | 1 | Synchronous software reset |
| stop | input | 1 | Engine stopped; opens the register port |
| timer_en | input | 1 | Enables tenure limiting |
| test_en | input | 1 | Test mode: writes step the countdown, prescaler frozen |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data; low 16 bits used |
| reg_rdata | output | 32 | Read data; upper 16 bits zero |
| grant | input | 1 | Engine holds the bus |
| burst_mode | input | 1 | Linear-burst mode selected |
| desc_phase | input | 1 | Current transfer is a descriptor access |
| xfer_done | input | 1 | One transfer completed this cycle |
| burst_last | input | 1 | Completed transfer ends a linear burst |
| release_req | output | 1 | Request to give up the bus |
| expired | output | 1 | Tenure limit reached in this tenure |

## Verification
The hardest case to reach is an expiry that lands in the middle of a three-transfer group, followed by a descriptor transfer arriving before the group closes. Only that case separates correct group counting and descriptor masking from a design that counts every transfer. The bench runs the prescaler with a small division and a limit of one tick. It issues two data transfers before expiry, waits for the expired flag, and then sends a descriptor transfer followed by one data transfer. The release must come with the data transfer and not with the descriptor transfer. Test mode is reached by keeping stop and test_en high across a grant, so that register writes alone drive the countdown to zero.

// File: rtl/btl_pkg.sv
package btl_pkg;
  localparam int unsigned LIMIT_W = 16;
  localparam int unsigned BUS_W   = 32;
  typedef logic [LIMIT_W-1:0] limit_t;
endpackage

// File: rtl/btl_limit_reg.sv
module btl_limit_reg
  import btl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             stop,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output limit_t           limit,
  output logic             wr_accept
);
  localparam int unsigned PAD_W = BUS_W - LIMIT_W;

  assign wr_accept = reg_wr & stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          limit <= '0;
    else if (sw_reset)   limit <= '0;
    else if (wr_accept)  limit <= reg_wdata[LIMIT_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && stop) reg_rdata = {{PAD_W{1'b0}}, limit};
  end

  // R1: writes while running leave the limit alone
  a_r1_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !stop && !sw_reset) |=> $stable(limit));
  // R2: software reset clears the limit
  a_r2_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (limit == '0));
endmodule

// File: rtl/btl_prescaler.sv
module btl_prescaler #(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (run)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R10: a frozen prescaler never ticks
  a_r10_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/btl_countdown.sv
module btl_countdown
  import btl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_reset,
  input  logic   grant,
  input  logic   load,
  input  limit_t limit,
  input  logic   tick,
  input  logic   test_step,
  output logic   expired
);
  limit_t count;
  limit_t count_nxt;

  always_comb begin
    count_nxt = count;
    if ((tick || test_step) && count != '0) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (sw_reset) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (load) begin
      count   <= limit;
      expired <= (limit == '0);
    end else begin
      count   <= count_nxt;
      expired <= grant && (count_nxt == '0);
    end
  end

  // R10: a spent counter stays at zero until reloaded
  a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> (count == '0));
  // R4: no expiry outside a tenure
  a_r4_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> !expired);
endmodule

// File: rtl/btl_release.sv
module btl_release #(
  parameter int unsigned GROUP_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic grant,
  input  logic expired,
  input  logic timer_en,
  input  logic burst_mode,
  input  logic desc_phase,
  input  logic xfer_done,
  input  logic burst_last,
  output logic release_req
);
  localparam int unsigned GRP_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_LEN - 1);

  logic [GRP_W-1:0] grp;
  logic data_xfer;
  logic boundary;

  assign data_xfer = grant && xfer_done && !desc_phase;
  assign boundary  = burst_mode ? burst_last : (grp == GRP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     grp <= '0;
    else if (sw_reset || !grant)    grp <= '0;
    else if (data_xfer && !burst_mode)
      grp <= (grp == GRP_LAST) ? '0 : grp + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        release_req <= 1'b0;
    else if (sw_reset) release_req <= 1'b0;
    else release_req <= grant &&
      (release_req || (timer_en && expired && data_xfer && boundary));
  end

  // R11: request drops once the bus is given up
  a_r11_drop_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> !release_req);
  // R6/R7: a new request only follows expiry
  a_r7_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_req && !expired) |=> !release_req);
  // R9: descriptor transfers never start a request
  a_r9_desc_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_req && desc_phase) |=> !release_req);
  // R5: disabled timer never requests release
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_req && !timer_en) |=> !release_req);
endmodule

// File: rtl/bus_tenure_limiter.sv
module bus_tenure_limiter
  import btl_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 10,
  parameter int unsigned GROUP_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             stop,
  input  logic             timer_en,
  input  logic             test_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             grant,
  input  logic             burst_mode,
  input  logic             desc_phase,
  input  logic             xfer_done,
  input  logic             burst_last,
  output logic             release_req,
  output logic             expired
);
  logic   grant_q;
  logic   grant_rise;
  logic   wr_accept;
  logic   tick;
  limit_t limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        grant_q <= 1'b0;
    else if (sw_reset) grant_q <= 1'b0;
    else               grant_q <= grant;
  end
  assign grant_rise = grant && !grant_q;

  btl_limit_reg u_reg (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stop(stop),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .limit(limit), .wr_accept(wr_accept)
  );

  btl_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .clr(sw_reset || !grant || grant_rise),
    .run(grant && !test_en),
    .tick(tick)
  );

  btl_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .grant(grant),
    .load(grant_rise), .limit(limit), .tick(tick),
    .test_step(test_en && wr_accept),
    .expired(expired)
  );

  btl_release #(.GROUP_LEN(GROUP_LEN)) u_rel (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .grant(grant),
    .expired(expired), .timer_en(timer_en), .burst_mode(burst_mode),
    .desc_phase(desc_phase), .xfer_done(xfer_done),
    .burst_last(burst_last), .release_req(release_req)
  );
endmodule

// File: tb/sim_bus_tenure_limiter.sv
module sim_bus_tenure_limiter;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic sw_reset = 0, stop = 0, timer_en = 0, test_en = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic grant = 0, burst_mode = 0, desc_phase = 0, xfer_done = 0, burst_last = 0;
  logic release_req, expired;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_tenure_limiter #(.TICK_DIV(DIV), .GROUP_LEN(3)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stop(stop),
    .timer_en(timer_en), .test_en(test_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grant(grant),
    .burst_mode(burst_mode), .desc_phase(desc_phase), .xfer_done(xfer_done),
    .burst_last(burst_last), .release_req(release_req), .expired(expired)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic steps(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    reg_wr = 1; reg_wdata = v;
    steps(1);
    reg_wr = 0;
  endtask

  task automatic rd_check(string req, logic [31:0] exp);
    logic save;
    save = stop;
    stop = 1; reg_rd = 1;
    #1 check(req, reg_rdata, exp);
    reg_rd = 0; stop = save;
  endtask

  task automatic xfer(logic last, logic desc);
    xfer_done = 1; burst_last = last; desc_phase = desc;
    steps(1);
    xfer_done = 0; burst_last = 0; desc_phase = 0;
  endtask

  task automatic end_tenure();
    grant = 0;
    steps(1);
    check("R11 release low after grant drop", release_req, 0);
    check("R4 expired low after grant drop", expired, 0);
  endtask

  task automatic t_register();
    rd_check("R2 reset value", 0);
    stop = 1; wr(32'hABCD_0005); stop = 0;
    rd_check("R1 low half stored", 32'h5);
    wr(32'h1234);
    rd_check("R1 write ignored when stop low", 32'h5);
    reg_rd = 1; #1 check("R1 read zero when stop low", reg_rdata, 0); reg_rd = 0;
    stop = 1; steps(2); stop = 0; steps(2);
    rd_check("R2 stop leaves limit", 32'h5);
    sw_reset = 1; steps(1); sw_reset = 0;
    rd_check("R2 software reset clears", 0);
  endtask

  task automatic t_timing();
    stop = 1; wr(3); stop = 0;
    timer_en = 1;
    grant = 1;
    for (int m = 1; m <= 13; m++) begin
      steps(1);
      if (m == 12) check("R3 not expired before L*DIV", expired, 0);
      if (m == 13) check("R3 expired at L*DIV", expired, 1);
    end
    steps(5);
    check("R4 expired holds in tenure", expired, 1);
    end_tenure();
  endtask

  task automatic t_burst();
    stop = 1; wr(1); stop = 0;
    burst_mode = 1; grant = 1;
    steps(DIV + 2);
    check("R6 expired", expired, 1);
    xfer(0, 0);
    check("R6 no release mid-burst", release_req, 0);
    xfer(1, 0);
    check("R6 release at burst end", release_req, 1);
    steps(3);
    check("R11 release held", release_req, 1);
    end_tenure();
    burst_mode = 0;
  endtask

  task automatic t_group_desc();
    stop = 1; wr(1); stop = 0;
    grant = 1;
    steps(1);
    xfer(0, 0); xfer(0, 0);
    steps(DIV);
    check("R7 expired", expired, 1);
    check("R7 no release before group end", release_req, 0);
    xfer(0, 1);
    check("R9 descriptor no release", release_req, 0);
    xfer(0, 0);
    check("R7 release at group end", release_req, 1);
    end_tenure();
  endtask

  task automatic t_zero();
    stop = 1; wr(0); stop = 0;
    grant = 1; steps(1);
    check("R8 zero limit expires at load", expired, 1);
    xfer(0, 0); xfer(0, 0);
    check("R8 two transfers not enough", release_req, 0);
    xfer(0, 0);
    check("R8 release after one group", release_req, 1);
    end_tenure();
    burst_mode = 1; grant = 1; steps(1);
    xfer(1, 0);
    check("R8 release after one burst", release_req, 1);
    end_tenure();
    burst_mode = 0;
    timer_en = 0; grant = 1; steps(1);
    xfer(0, 0); xfer(0, 0); xfer(0, 0); xfer(0, 0);
    check("R5 disabled no release", release_req, 0);
    end_tenure();
    timer_en = 1;
  endtask

  task automatic t_testmode();
    stop = 1; test_en = 1;
    wr(3);
    grant = 1; steps(1);
    check("R10 loaded not expired", expired, 0);
    steps(3 * DIV + 4);
    check("R10 prescaler frozen", expired, 0);
    wr(3); wr(3);
    check("R10 two steps not expired", expired, 0);
    wr(3);
    check("R10 third step expires", expired, 1);
    end_tenure();
    test_en = 0; stop = 0;
  endtask

  initial begin
    steps(3);
    rst_n = 1;
    steps(2);
    t_register();
    t_timing();
    t_burst();
    t_group_desc();
    t_zero();
    t_testmode();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule